// File: doc/BRIEF.md
# Event and Window Timer/Counter

This block is a 16-bit up-counter with a compare value, used to count pulses on an external pin or to measure how long that pin stays high. In event mode the counter advances on every rising edge of the pin. In window mode it advances on rising edges of one selected internal prescaler tap, but only while the pin is high. When the count reaches the compare value, the block emits a one-cycle interrupt pulse and restarts from zero.

Software sets the block up through a small write port. It first writes the mode and the tap selection with the run bit clear, then writes the same value again with the run bit set. The pin is asynchronous. It passes through a two-flop synchroniser, and edge detection then runs in the system clock domain. Each level of the pin must therefore last at least two clock cycles. A low-power indicator marks the slow clock mode, in which window counting is not permitted. If the indicator rises while window counting runs, counting freezes and a sticky error flag is set.

Top module: `evwin_timer`

## Requirements
- R1: After reset the count is 0, `irq` and `err_lowpwr` are low, and the control register is 0 (stopped, event mode, tap 0).
- R2: In event mode with the run bit set, each rising edge of `ext_in` adds one to the count. Each level of `ext_in` must be held at least two clock cycles.
- R3: In event mode the compare is evaluated only at a falling edge of `ext_in`. A rising edge that brings the count equal to the compare value raises no interrupt. The next falling edge pulses `irq` and clears the count to 0.
- R4: After a match clears the count, further rising edges count up again from 0.
- R5: In window mode (control bit 0 = 1) with the run bit set, each rising edge of the selected tap adds one to the count, but only while the synchronised `ext_in` is high. Tap edges while it is low have no effect. A tap edge that would make the count equal the compare value instead clears the count and pulses `irq`.
- R6: Control bits [4:2] give the index of the tap in `taps` that drives window counting. Edges on any other tap leave the count unchanged.
- R7: Control bit 5 is the run bit. While it is 0 the count holds its value. A control write that sets it while it was 0 clears the count to 0. `wr_sel` = 0 writes the control register from `wr_data[7:0]`, and `wr_sel` = 1 writes the 16-bit compare register.
- R8: In window mode with the run bit set, `low_pwr` high stops the count from advancing and sets `err_lowpwr`. The flag stays set until reset.
- R9: `irq` is high for exactly one clock cycle per match.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = compare register |
| wr_data | input | 16 | Write data |
| ext_in | input | 1 | Asynchronous external pin |
| taps | input | 8 | Prescaler tap clocks (system-clock-domain levels) |
| low_pwr | input | 1 | Low-speed clock mode indicator |
| cnt_o | output | 16 | Current count |
| irq | output | 1 | One-cycle match interrupt |
| err_lowpwr | output | 1 | Sticky flag: window counting attempted in low-power mode |

## Verification
A wrong count shows up on `cnt_o` at the third clock edge after a pin transition: two synchroniser stages plus the counter register. A wrong match decision shows up one edge after the deciding falling edge or tap edge. At that point the count fails to return to 0, or `irq` pulses at a rising edge where it should stay silent. A broken run or clear path appears on the first pin pulse after the control write, and a faulty tap select appears on the first pulse of an unselected tap. A missing sticky behaviour appears once `low_pwr` drops again.

// File: rtl/evwin_pkg.sv
package evwin_pkg;
    localparam int CTRL_W    = 8;
    localparam int MODE_BIT  = 0;
    localparam int SEL_LSB   = 2;
    localparam int SEL_W     = 3;
    localparam int START_BIT = 5;
    localparam int NTAPS     = 1 << SEL_W;

    typedef enum logic {
        MODE_EVENT  = 1'b0,
        MODE_WINDOW = 1'b1
    } mode_e;

    typedef struct packed {
        logic             start;
        logic [SEL_W-1:0] sel;
        mode_e            mode;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] v);
        ctrl_t c;
        c.start = v[START_BIT];
        c.sel   = v[SEL_LSB +: SEL_W];
        c.mode  = mode_e'(v[MODE_BIT]);
        return c;
    endfunction
endpackage

// File: rtl/evwin_edge.sv
module evwin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign lvl  = sync_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/evwin_tick.sv
module evwin_tick
    import evwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NTAPS-1:0] taps,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic tap_now;
    logic tap_q;

    assign tap_now = taps[sel];

    always_ff @(posedge clk) begin
        if (rst) tap_q <= 1'b0;
        else     tap_q <= tap_now;
    end

    assign tick = tap_now & ~tap_q;
endmodule

// File: rtl/evwin_count.sv
module evwin_count
    import evwin_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start_clr,
    input  mode_e            mode,
    input  logic             ext_lvl,
    input  logic             ext_rise,
    input  logic             ext_fall,
    input  logic             tick,
    input  logic             low_pwr,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             err
);
    logic [CNT_W-1:0] nxt;
    assign nxt = cnt + {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
            err <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start_clr) begin
                cnt <= '0;
            end else if (run) begin
                if (mode == MODE_EVENT) begin
                    if (ext_fall && cnt == cmp) begin
                        cnt <= '0;
                        irq <= 1'b1;
                    end else if (ext_rise) begin
                        cnt <= nxt;
                    end
                end else begin
                    if (low_pwr) begin
                        err <= 1'b1;
                    end else if (tick && ext_lvl) begin
                        if (nxt == cmp) begin
                            cnt <= '0;
                            irq <= 1'b1;
                        end else begin
                            cnt <= nxt;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/evwin_timer.sv
module evwin_timer
    import evwin_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_in,
    input  logic [NTAPS-1:0] taps,
    input  logic             low_pwr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq,
    output logic             err_lowpwr
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [CNT_W-1:0] cmp_q;
    logic             start_clr;
    logic             ext_lvl, ext_rise, ext_fall;
    logic             tick;

    assign ctrl_new  = decode_ctrl(wr_data[CTRL_W-1:0]);
    assign start_clr = wr_en && !wr_sel && ctrl_new.start && !ctrl_q.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) cmp_q  <= wr_data;
            else        ctrl_q <= ctrl_new;
        end
    end

    evwin_edge #(.STAGES(SYNC_STGS)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (ext_in),
        .lvl (ext_lvl),
        .rise(ext_rise),
        .fall(ext_fall)
    );

    evwin_tick u_tick (
        .clk (clk),
        .rst (rst),
        .taps(taps),
        .sel (ctrl_q.sel),
        .tick(tick)
    );

    evwin_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.start),
        .start_clr(start_clr),
        .mode     (ctrl_q.mode),
        .ext_lvl  (ext_lvl),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .tick     (tick),
        .low_pwr  (low_pwr),
        .cmp      (cmp_q),
        .cnt      (cnt_o),
        .irq      (irq),
        .err      (err_lowpwr)
    );
endmodule

// File: rtl/evwin_timer_chk.sv
module evwin_timer_chk
    import evwin_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             low_pwr,
    input logic [CNT_W-1:0] cnt_o,
    input logic             irq,
    input logic             err_lowpwr,
    input ctrl_t            ctrl_q,
    input logic             ext_lvl
);
    logic start_wr;
    assign start_wr = wr_en && !wr_sel && wr_data[START_BIT];

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R9

    AST_IRQ_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt_o == '0)); // R3

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(!ctrl_q.start && !start_wr) |-> $stable(cnt_o)); // R7

    AST_WINDOW_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q.mode == MODE_WINDOW && !ext_lvl && !start_wr) |-> $stable(cnt_o)); // R5

    AST_LOWPWR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.start && ctrl_q.mode == MODE_WINDOW && low_pwr) |=> err_lowpwr); // R8

    AST_LOWPWR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_lowpwr |=> err_lowpwr); // R8

    AST_LOWPWR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q.mode == MODE_WINDOW && low_pwr && !start_wr) |-> $stable(cnt_o)); // R8
endmodule

bind evwin_timer evwin_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .low_pwr   (low_pwr),
    .cnt_o     (cnt_o),
    .irq       (irq),
    .err_lowpwr(err_lowpwr),
    .ctrl_q    (ctrl_q),
    .ext_lvl   (ext_lvl)
);

// File: tb/tb_evwin_timer.sv
module tb_evwin_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ext_in = 1'b0;
    logic [7:0]  taps = '0;
    logic        low_pwr = 1'b0;
    logic [15:0] cnt_o;
    logic        irq;
    logic        err_lowpwr;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_seen = 0;
    logic irq_prev = 1'b0;
    logic done = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        int          irqs;
        logic        err;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    evwin_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ext_in(ext_in), .taps(taps), .low_pwr(low_pwr),
        .cnt_o(cnt_o), .irq(irq), .err_lowpwr(err_lowpwr)
    );

    // Monitor: counts irq pulses, checks pulse width, and scores queued items
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_seen++;
            if (irq && irq_prev) begin
                n_tests++; n_fail++;
                $display("FAIL R9 irq high two cycles: actual 1 expected 0");
            end
            irq_prev = irq;
        end
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (cnt_o !== e.cnt || irq_seen != e.irqs || err_lowpwr !== e.err) begin
                n_fail++;
                $display("FAIL %s: actual cnt=%0d irqs=%0d err=%0b expected cnt=%0d irqs=%0d err=%0b",
                         e.tag, cnt_o, irq_seen, err_lowpwr, e.cnt, e.irqs, e.err);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input int c, input int irqs, input logic e);
        exp_t x;
        cyc(1);
        x.tag = tag; x.cnt = 16'(c); x.irqs = irqs; x.err = e;
        exp_q.push_back(x);
        cyc(2);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
        cyc(1);
    endtask

    task automatic pin_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1'b1; cyc(4);
            ext_in = 1'b0; cyc(4);
        end
    endtask

    task automatic tap_pulse(input int idx);
        taps[idx] = 1'b1; cyc(2);
        taps[idx] = 1'b0; cyc(2);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        expect_state("R1 reset state", 0, 0, 1'b0);

        // Event mode, compare = 3
        wr(1'b1, 16'd3);
        wr(1'b0, 16'h001C);
        wr(1'b0, 16'h003C);
        pin_pulse(2);
        expect_state("R2 two rising edges", 2, 0, 1'b0);
        ext_in = 1'b1; cyc(4);
        expect_state("R3 equal at rise, no irq yet", 3, 0, 1'b0);
        ext_in = 1'b0; cyc(4);
        expect_state("R3 match at falling edge clears", 0, 1, 1'b0);
        pin_pulse(2);
        expect_state("R4 counting resumes from zero", 2, 1, 1'b0);

        // Stop holds, restart clears
        wr(1'b0, 16'h001C);
        pin_pulse(2);
        expect_state("R7 stopped counter holds", 2, 1, 1'b0);
        wr(1'b0, 16'h003C);
        expect_state("R7 start write clears", 0, 1, 1'b0);

        // Window mode, tap 1
        wr(1'b0, 16'h001C);
        wr(1'b0, 16'h0005);
        wr(1'b0, 16'h0025);
        tap_pulse(1); tap_pulse(1);
        expect_state("R5 ticks ignored while pin low", 0, 1, 1'b0);
        ext_in = 1'b1; cyc(4);
        tap_pulse(1); tap_pulse(1);
        expect_state("R5 ticks counted while pin high", 2, 1, 1'b0);
        tap_pulse(0); tap_pulse(3); tap_pulse(7);
        expect_state("R6 unselected taps ignored", 2, 1, 1'b0);
        tap_pulse(1);
        expect_state("R5 window match clears and interrupts", 0, 2, 1'b0);
        tap_pulse(1);
        expect_state("R5 window resumes", 1, 2, 1'b0);

        // Low-power mode in window counting
        low_pwr = 1'b1; cyc(1);
        tap_pulse(1);
        expect_state("R8 frozen and flagged in low power", 1, 2, 1'b1);
        low_pwr = 1'b0; cyc(1);
        expect_state("R8 flag sticky", 1, 2, 1'b1);
        tap_pulse(1);
        expect_state("R8 counting resumes after low power", 2, 2, 1'b1);

        // Tap select 7 drives counting, tap 1 no longer does
        wr(1'b0, 16'h0021 | 16'h001C);
        tap_pulse(1);
        expect_state("R6 old tap ignored after reselect", 2, 2, 1'b1);
        tap_pulse(7);
        expect_state("R6 tap 7 selected", 0, 3, 1'b1);

        cyc(4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule